// File: doc/BRIEF.md
# DES Single-Round Execution Unit

This unit carries out one round of the Data Encryption Standard each time a round instruction is issued to it. The caller presents a 16-byte register window: eight bytes hold the 64-bit text block and eight bytes hold the full 64-bit key, parity bits included. The unit returns an updated copy of both halves of the window for write-back. A complete ECB encryption or decryption takes sixteen issues with round indices 0 through 15, in increasing order. The direction flag selects encryption or decryption on every issue.

Every round applies the initial permutation to the text on entry and the inverse permutation on exit. The text written back between rounds is therefore not the textbook intermediate value, but the block after round 15 is the standard result. The key bytes are rewritten in place on every round. The two 28-bit halves selected from the key rotate left when encrypting and right when decrypting, and the parity bits are kept unchanged. After sixteen rounds the key image is back at its starting value. Round 15 leaves out the half swap.

Issue uses a valid/ready handshake. `in_ready` is low while a slow issue is in its extra cycle, and also while a result waits with `out_ready` low. A result is offered with `out_valid`, which also serves as the write-back strobe. The result stays stable until `out_ready` takes it. The latency is one cycle when the caller marks the previous instruction as a round instruction, and two cycles otherwise.

Top module: `des_round_unit`

## Requirements
- R1: An issue is a round instruction only when the opcode matches 1001_0100_KKKK_1011 (bits [15:8] = 0x94, bits [3:0] = 0xB). Any other opcode is taken by the handshake and produces no write-back and no busy cycle.
- R2: Text bit i is `data_in[i]` and key bit i is `key_in[i]`. Register byte n of the text occupies bits [8n+7:8n], so text bit 0 is the LSB of byte 0 and text bit 63 is the MSB of byte 7. Key byte 8+n occupies `key_in[8n+7:8n]` in the same way. As a 64-bit integer, the text and key read as in the usual DES hex notation.
- R3: The round index is opcode bits [7:4]. If `prev_des` is 1 at the accepting edge, `out_valid` rises on the next edge. If it is 0, `busy` is high for one cycle and `out_valid` rises one edge later. `in_ready` is low while `busy` is high.
- R4: With `decrypt` = 0, rounds 0 to 15 chained from plaintext 0x0123456789ABCDEF and key 0x133457799BBCDFF1 give text 0x85E813540F0AB405 after round 15.
- R5: With `decrypt` = 1, rounds 0 to 15 chained from that ciphertext and the same key give back the plaintext.
- R6: After sixteen chained rounds in either direction, the key output equals the original key, parity bits included.
- R7: While `out_valid` is high and `out_ready` is low, `data_out` and `key_out` hold their values, `out_valid` stays high and `in_ready` is low.
- R8: After reset, `out_valid` and `busy` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue request |
| in_ready | output | 1 | Unit can take an issue this cycle |
| opcode | input | 16 | Instruction word to decode |
| decrypt | input | 1 | 0 encrypts, 1 decrypts |
| prev_des | input | 1 | Previous instruction was a round instruction |
| data_in | input | 64 | Text bytes 0-7 of the register window |
| key_in | input | 64 | Key bytes 8-15 of the register window |
| out_valid | output | 1 | Result offered; write-back strobe |
| out_ready | input | 1 | Consumer takes the result |
| data_out | output | 64 | Updated text bytes |
| key_out | output | 64 | Updated key bytes |
| busy | output | 1 | Extra cycle of a slow issue in progress |

## Verification
The standard output only appears at the end of a sixteen-issue chain. In that chain each issue must use the exact bytes written back by the round before it, and the round indices must run in order. The bench drives this chain in both directions, feeding each accepted result into the next issue. In the decrypt chain it sets `prev_des` low on every fourth issue, so that both latencies occur within one operation. It holds `out_ready` low while a result is pending to test hold and stall, and it sends near-miss opcodes to show that they are dropped.

// File: rtl/des_round_pkg.sv
package des_round_pkg;
  localparam int BLK_W  = 64;
  localparam int HALF_W = 32;
  localparam int CD_W   = 56;
  localparam int HCD_W  = 28;
  localparam int SK_W   = 48;
  localparam int NBOX   = 8;
  localparam int OP_W   = 16;
  localparam int RND_W  = 4;
  localparam int LAST_RND = (1 << RND_W) - 1;

  // key bit selection, standard 1-based numbering with 1 as MSB
  localparam int PC1_T [CD_W] = '{
    57,49,41,33,25,17, 9, 1,58,50,42,34,26,18,
    10, 2,59,51,43,35,27,19,11, 3,60,52,44,36,
    63,55,47,39,31,23,15, 7,62,54,46,38,30,22,
    14, 6,61,53,45,37,29,21,13, 5,28,20,12, 4};
  localparam int PC2_T [SK_W] = '{
    14,17,11,24, 1, 5, 3,28,15, 6,21,10,
    23,19,12, 4,26, 8,16, 7,27,20,13, 2,
    41,52,31,37,47,55,30,40,51,45,33,48,
    44,49,39,56,34,53,46,42,50,36,29,32};
  localparam int P_T [HALF_W] = '{
    16, 7,20,21,29,12,28,17, 1,15,23,26, 5,18,31,10,
     2, 8,24,14,32,27, 3, 9,19,13,30, 6,22,11, 4,25};
  // substitution boxes, 64 nibbles each, row-major, first entry in the top nibble
  localparam logic [255:0] SBOX_T [NBOX] = '{
    256'hE4D12FB83A6C59070F74E2D1A6CB953841E8D62BFC973A50FC8249175B3EA06D,
    256'hF18E6B34972DC05A3D47F28EC01A69B50E7BA4D158C6932FD8A13F42B67C05E9,
    256'hA09E63F51DC7B428D709346A285ECBF1D6498F30B12C5AE71AD069874FE3B52C,
    256'h7DE3069A1285BC4FD8B56F03472C1AE9A690CB7DF13E52843F06A1D8945BC72E,
    256'h2C417AB6853FD0E9EB2C47D150FA3986421BAD78F9C5630EB8C71E2D6F09A453,
    256'hC1AF92680D34E75BAF427C9561DE0B389EF528C3704A1DB6432C95FABE17608D,
    256'h4B2EF08D3C975A61D0B7491AE35C2F8614BDC37EAF6805926BD814A7950FE23C,
    256'hD2846FB1A93E50C71FD8A374C56B0E927B419CE206ADF35821E74A8DFC90356B};

  // 1-based source bit of output position i+1 of the initial permutation
  function automatic int ip_src(input int i);
    int r;
    int c;
    r = i / 8;
    c = i % 8;
    return ((r < 4) ? (58 + 2 * r) : (49 + 2 * r)) - 8 * c;
  endfunction

  function automatic logic [BLK_W-1:0] ip_fwd(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    y = '0;
    for (int i = 0; i < BLK_W; i++) y[BLK_W-1-i] = x[BLK_W-ip_src(i)];
    return y;
  endfunction

  function automatic logic [BLK_W-1:0] ip_bwd(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    y = '0;
    for (int i = 0; i < BLK_W; i++) y[BLK_W-ip_src(i)] = x[BLK_W-1-i];
    return y;
  endfunction

  function automatic logic [SK_W-1:0] expand(input logic [HALF_W-1:0] r);
    logic [SK_W-1:0] y;
    int src;
    y = '0;
    for (int j = 0; j < SK_W; j++) begin
      src = (((j / 6) * 4 + (j % 6) + HALF_W - 1) % HALF_W) + 1;
      y[SK_W-1-j] = r[HALF_W-src];
    end
    return y;
  endfunction

  function automatic logic [HALF_W-1:0] pperm(input logic [HALF_W-1:0] x);
    logic [HALF_W-1:0] y;
    y = '0;
    for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = x[HALF_W-P_T[i]];
    return y;
  endfunction

  function automatic logic [CD_W-1:0] pc1(input logic [BLK_W-1:0] k);
    logic [CD_W-1:0] y;
    y = '0;
    for (int i = 0; i < CD_W; i++) y[CD_W-1-i] = k[BLK_W-PC1_T[i]];
    return y;
  endfunction

  // scatter the halves back into the key image, parity bits taken from keep
  function automatic logic [BLK_W-1:0] pc1_back(input logic [CD_W-1:0] cd,
                                               input logic [BLK_W-1:0] keep);
    logic [BLK_W-1:0] y;
    y = keep;
    for (int i = 0; i < CD_W; i++) y[BLK_W-PC1_T[i]] = cd[CD_W-1-i];
    return y;
  endfunction

  function automatic logic [SK_W-1:0] pc2(input logic [CD_W-1:0] cd);
    logic [SK_W-1:0] y;
    y = '0;
    for (int i = 0; i < SK_W; i++) y[SK_W-1-i] = cd[CD_W-PC2_T[i]];
    return y;
  endfunction

  function automatic logic [HCD_W-1:0] rot_l(input logic [HCD_W-1:0] x, input logic one);
    return one ? {x[HCD_W-2:0], x[HCD_W-1]} : {x[HCD_W-3:0], x[HCD_W-1:HCD_W-2]};
  endfunction

  function automatic logic [HCD_W-1:0] rot_r(input logic [HCD_W-1:0] x, input logic one);
    return one ? {x[0], x[HCD_W-1:1]} : {x[1:0], x[HCD_W-1:2]};
  endfunction

  // schedule positions that rotate by a single bit
  function automatic logic single_step(input logic [RND_W-1:0] k);
    return (k == 4'd0) || (k == 4'd1) || (k == 4'd8) || (k == 4'd15);
  endfunction

  function automatic logic [3:0] sbox_lookup(input int b, input logic [5:0] s);
    logic [5:0] idx;
    idx = {s[5], s[0], s[4:1]};
    return SBOX_T[b][255 - 4 * int'(idx) -: 4];
  endfunction
endpackage

// File: rtl/des_key_step.sv
module des_key_step
  import des_round_pkg::*;
(
  input  logic [BLK_W-1:0] key_cur,
  input  logic [RND_W-1:0] round,
  input  logic             decrypt,
  output logic [SK_W-1:0]  subkey,
  output logic [BLK_W-1:0] key_next
);
  logic [CD_W-1:0]  cd;
  logic [CD_W-1:0]  cd_rot;
  logic [RND_W-1:0] sched_pos;
  logic             one;

  assign cd        = pc1(key_cur);
  // decryption walks the schedule backwards
  assign sched_pos = decrypt ? (RND_W'(LAST_RND) - round) : round;
  assign one       = single_step(sched_pos);

  always_comb begin
    if (decrypt) begin
      subkey = pc2(cd);
      cd_rot = {rot_r(cd[CD_W-1:HCD_W], one), rot_r(cd[HCD_W-1:0], one)};
    end else begin
      cd_rot = {rot_l(cd[CD_W-1:HCD_W], one), rot_l(cd[HCD_W-1:0], one)};
      subkey = pc2(cd_rot);
    end
  end

  assign key_next = pc1_back(cd_rot, key_cur);
endmodule

// File: rtl/des_feistel_f.sv
module des_feistel_f
  import des_round_pkg::*;
(
  input  logic [HALF_W-1:0] r_half,
  input  logic [SK_W-1:0]   subkey,
  output logic [HALF_W-1:0] f_out
);
  logic [SK_W-1:0]   mixed;
  logic [HALF_W-1:0] sub_out;

  assign mixed = expand(r_half) ^ subkey;

  for (genvar b = 0; b < NBOX; b++) begin : g_box
    assign sub_out[HALF_W-1-4*b -: 4] = sbox_lookup(b, mixed[SK_W-1-6*b -: 6]);
  end

  assign f_out = pperm(sub_out);
endmodule

// File: rtl/des_round_core.sv
module des_round_core
  import des_round_pkg::*;
(
  input  logic [BLK_W-1:0] data_cur,
  input  logic [BLK_W-1:0] key_cur,
  input  logic [RND_W-1:0] round,
  input  logic             decrypt,
  output logic [BLK_W-1:0] data_next,
  output logic [BLK_W-1:0] key_next
);
  logic [BLK_W-1:0]  perm_in;
  logic [HALF_W-1:0] left_h;
  logic [HALF_W-1:0] right_h;
  logic [HALF_W-1:0] f_val;
  logic [HALF_W-1:0] mixed_l;
  logic [SK_W-1:0]   subkey;
  logic [BLK_W-1:0]  pre_out;

  des_key_step u_key (
    .key_cur (key_cur),
    .round   (round),
    .decrypt (decrypt),
    .subkey  (subkey),
    .key_next(key_next)
  );

  assign perm_in = ip_fwd(data_cur);
  assign left_h  = perm_in[BLK_W-1:HALF_W];
  assign right_h = perm_in[HALF_W-1:0];

  des_feistel_f u_f (
    .r_half(right_h),
    .subkey(subkey),
    .f_out (f_val)
  );

  assign mixed_l = left_h ^ f_val;
  // the last round keeps the halves in place
  assign pre_out = (round == RND_W'(LAST_RND)) ? {mixed_l, right_h} : {right_h, mixed_l};
  assign data_next = ip_bwd(pre_out);
endmodule

// File: rtl/des_round_unit.sv
module des_round_unit
  import des_round_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  opcode,
  input  logic             decrypt,
  input  logic             prev_des,
  input  logic [BLK_W-1:0] data_in,
  input  logic [BLK_W-1:0] key_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BLK_W-1:0] data_out,
  output logic [BLK_W-1:0] key_out,
  output logic             busy
);
  logic             hold_q;
  logic [BLK_W-1:0] op_data_q;
  logic [BLK_W-1:0] op_key_q;
  logic [RND_W-1:0] op_rnd_q;
  logic             op_dec_q;
  logic             oval_q;
  logic [BLK_W-1:0] dout_q;
  logic [BLK_W-1:0] kout_q;

  logic             is_round;
  logic             take;
  logic [BLK_W-1:0] core_d;
  logic [BLK_W-1:0] core_k;
  logic [RND_W-1:0] core_r;
  logic             core_dec;
  logic [BLK_W-1:0] res_d;
  logic [BLK_W-1:0] res_k;

  assign is_round = (opcode[15:8] == 8'h94) && (opcode[3:0] == 4'hB);
  assign in_ready = !hold_q && (!oval_q || out_ready);
  assign take     = in_valid && in_ready;

  // a single round core fed either by the live ports or by the held operands
  assign core_d   = hold_q ? op_data_q : data_in;
  assign core_k   = hold_q ? op_key_q  : key_in;
  assign core_r   = hold_q ? op_rnd_q  : opcode[7:4];
  assign core_dec = hold_q ? op_dec_q  : decrypt;

  des_round_core u_core (
    .data_cur (core_d),
    .key_cur  (core_k),
    .round    (core_r),
    .decrypt  (core_dec),
    .data_next(res_d),
    .key_next (res_k)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= 1'b0;
      op_data_q <= '0;
      op_key_q  <= '0;
      op_rnd_q  <= '0;
      op_dec_q  <= 1'b0;
      oval_q    <= 1'b0;
      dout_q    <= '0;
      kout_q    <= '0;
    end else begin
      if (oval_q && out_ready) oval_q <= 1'b0;
      if (hold_q) begin
        dout_q <= res_d;
        kout_q <= res_k;
        oval_q <= 1'b1;
        hold_q <= 1'b0;
      end else if (take && is_round) begin
        if (prev_des) begin
          dout_q <= res_d;
          kout_q <= res_k;
          oval_q <= 1'b1;
        end else begin
          op_data_q <= data_in;
          op_key_q  <= key_in;
          op_rnd_q  <= opcode[7:4];
          op_dec_q  <= decrypt;
          hold_q    <= 1'b1;
        end
      end
    end
  end

  assign out_valid = oval_q;
  assign data_out  = dout_q;
  assign key_out   = kout_q;
  assign busy      = hold_q;
endmodule

// File: rtl/des_round_unit_chk.sv
module des_round_unit_chk
  import des_round_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [OP_W-1:0]  opcode,
  input logic             prev_des,
  input logic             out_valid,
  input logic             out_ready,
  input logic [BLK_W-1:0] data_out,
  input logic [BLK_W-1:0] key_out,
  input logic             busy
);
  logic op_ok;
  assign op_ok = (opcode[15:8] == 8'h94) && (opcode[3:0] == 4'hB);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(data_out) && $stable(key_out));

  a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r3_busy_stall: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  a_r3_fast: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && op_ok && prev_des |=> out_valid && !busy);

  a_r3_slow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && op_ok && !prev_des |=> busy && !out_valid);

  a_r3_slow_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> out_valid && !busy);

  a_r1_drop: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !op_ok |=> !out_valid && !busy);
endmodule

bind des_round_unit des_round_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .opcode   (opcode),
  .prev_des (prev_des),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .data_out (data_out),
  .key_out  (key_out),
  .busy     (busy)
);

// File: tb/des_round_unit_test.sv
module des_round_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] opcode = '0;
  logic        decrypt = 1'b0;
  logic        prev_des = 1'b0;
  logic [63:0] data_in = '0;
  logic [63:0] key_in = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] data_out;
  logic [63:0] key_out;
  logic        busy;

  localparam logic [63:0] PT  = 64'h0123456789ABCDEF;
  localparam logic [63:0] KEY = 64'h133457799BBCDFF1;
  localparam logic [63:0] CT  = 64'h85E813540F0AB405;

  typedef struct {
    bit          chk;
    logic [63:0] d;
    logic [63:0] k;
    int          lat;
    int          t0;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  int          retired = 0;
  bit          seen = 0;
  logic [63:0] last_d;
  logic [63:0] last_k;

  des_round_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .opcode(opcode), .decrypt(decrypt), .prev_des(prev_des),
    .data_in(data_in), .key_in(key_in), .out_valid(out_valid),
    .out_ready(out_ready), .data_out(data_out), .key_out(key_out), .busy(busy)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rop(input int r);
    return {8'h94, 4'(r), 4'hB};
  endfunction

  // monitor: compare the front of the scoreboard on first sight of a result
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && !seen) begin
        seen = 1;
        if (sb.size() == 0) begin
          check(0, "R1", "write-back with nothing issued", data_out, '0);
        end else begin
          item_t e;
          e = sb.pop_front();
          check(cyc - e.t0 == e.lat, "R3", "latency", 64'(cyc - e.t0), 64'(e.lat));
          if (e.chk) begin
            check(data_out == e.d, e.tag, "text", data_out, e.d);
            check(key_out == e.k, "R6", "key image", key_out, e.k);
          end
        end
      end
      if (out_valid && out_ready) begin
        seen = 0;
        last_d = data_out;
        last_k = key_out;
        retired++;
      end
    end
  end

  // driver: present one issue and push what it should produce
  task automatic issue(input logic [15:0] op, input bit dir, input bit prev,
                       input logic [63:0] d, input logic [63:0] k,
                       input bit chk, input logic [63:0] ed, input logic [63:0] ek,
                       input string tag);
    item_t e;
    @(negedge clk);
    in_valid = 1; opcode = op; decrypt = dir; prev_des = prev;
    data_in = d; key_in = k;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    if (op[15:8] == 8'h94 && op[3:0] == 4'hB) begin
      e.chk = chk; e.d = ed; e.k = ek; e.lat = prev ? 1 : 2; e.t0 = cyc; e.tag = tag;
      sb.push_back(e);
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_retired(input int n);
    while (retired < n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual running expected done");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    logic [63:0] k;
    logic [63:0] snap;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(out_valid == 0, "R8", "out_valid after reset", 64'(out_valid), 0);
    check(busy == 0, "R8", "busy after reset", 64'(busy), 0);
    check(in_ready == 1, "R8", "in_ready after reset", 64'(in_ready), 1);
    rst_n = 1;
    @(negedge clk);

    // R4 / R2: encrypt chain, byte-ordered words in the usual hex notation
    d = PT; k = KEY;
    for (int r = 0; r < 16; r++) begin
      issue(rop(r), 0, r != 0, d, k, r == 15, CT, KEY, "R4");
      wait_retired(r + 1);
      d = last_d; k = last_k;
    end
    check(d == CT, "R4", "chained ciphertext", d, CT);
    check(k == KEY, "R6", "key after encrypt chain", k, KEY);

    // R5: decrypt chain, slow issue every fourth round
    d = CT; k = KEY;
    for (int r = 0; r < 16; r++) begin
      issue(rop(r), 1, (r % 4) != 0, d, k, r == 15, PT, KEY, "R5");
      wait_retired(16 + r + 1);
      d = last_d; k = last_k;
    end
    check(d == PT, "R5", "chained plaintext", d, PT);
    check(k == KEY, "R6", "key after decrypt chain", k, KEY);

    // R1: near-miss opcodes are swallowed
    issue(16'h94FA, 0, 1, PT, KEY, 0, '0, '0, "R1");
    check(busy == 0, "R1", "busy after bad opcode", 64'(busy), 0);
    issue(16'h950B, 0, 0, PT, KEY, 0, '0, '0, "R1");
    check(busy == 0, "R1", "busy after bad opcode", 64'(busy), 0);
    issue(16'h0000, 1, 1, PT, KEY, 0, '0, '0, "R1");
    repeat (4) @(negedge clk);
    check(out_valid == 0, "R1", "no write-back for bad opcodes", 64'(out_valid), 0);
    check(retired == 32, "R1", "retired count", 64'(retired), 32);

    // R7: hold a pending result under back-pressure
    out_ready = 0;
    issue(rop(0), 0, 1, PT, KEY, 0, '0, '0, "R7");
    snap = data_out;
    repeat (3) @(negedge clk);
    check(out_valid == 1, "R7", "out_valid held", 64'(out_valid), 1);
    check(data_out == snap, "R7", "text held", data_out, snap);
    check(in_ready == 0, "R7", "in_ready low while pending", 64'(in_ready), 0);
    out_ready = 1;
    wait_retired(33);
    @(negedge clk);
    check(out_valid == 0, "R7", "out_valid cleared after take", 64'(out_valid), 0);

    // R3: slow issue shows one busy cycle
    issue(rop(0), 0, 0, PT, KEY, 0, '0, '0, "R3");
    check(busy == 1 || out_valid == 1, "R3", "slow issue in progress", 64'(busy), 1);
    wait_retired(34);
    @(negedge clk);
    check(busy == 0, "R3", "busy idle at end", 64'(busy), 0);
    check(sb.size() == 0, "R3", "scoreboard drained", 64'(sb.size()), 0);
    finish_run();
  end
endmodule